// File: doc/BRIEF.md
# Packed SIMD Multiply and Dot-Product Unit

This block multiplies two 32-bit packed operands in one of five modes. It can form a single 16x16 product, two independent 16x16 lane products, or four 8x8 lane products packed as 16-bit fields. It can also sum two 16x16 lane products or four 8x8 lane products into one 32-bit value. Each operand carries its own signedness flag, and the flag applies to every lane of that operand.

One array of four lane multipliers serves every mode. The operand splitter feeds either 16-bit halves or bytes into the lanes, with each lane extended to 17 bits according to its flag. A merge stage then packs the lane products or adds them. The latency is fixed at two cycles. A new operation can enter on every cycle, and a valid flag moves alongside the data through both stages.

Top module: `pkd_mul_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_vld` and `out_res` are 0 after that edge. Reset is synchronous.
- R2: Each operation accepted with `in_vld` high produces `out_vld` high with its result exactly two rising edges later. A cycle with `in_vld` low produces `out_vld` low two edges later.
- R3: `in_op` = 0 (single multiply) gives `out_res[31:0]` = `in_a[15:0]` x `in_b[15:0]`. Operand A is read as signed when `in_sgn_a` is 1 and as unsigned otherwise, and operand B follows `in_sgn_b` in the same way. `out_res[63:32]` is 0.
- R4: `in_op` = 1 (dual multiply) gives the product of the low halves in `out_res[31:0]` and the product of the high halves (`[31:16]`) in `out_res[63:32]`. Each product is 32 bits and follows the same signedness rule as R3.
- R5: `in_op` = 2 (quad byte multiply) places byte lane k's product, `in_a[8k+7:8k]` x `in_b[8k+7:8k]`, in `out_res[16k+15:16k]` as its low 16 bits. The signedness rule of R3 applies per byte.
- R6: `in_op` = 3 (dual dot product) gives `out_res[31:0]` = sum of the two 16x16 half products, wrapped modulo 2^32 with no saturation. `out_res[63:32]` is 0.
- R7: `in_op` = 4 (quad dot product) gives `out_res[31:0]` = sum of the four 8x8 byte products, each taken at its full value and wrapped modulo 2^32. `out_res[63:32]` is 0.
- R8: The unused `in_op` codes 5, 6 and 7 give `out_vld` high with `out_res` = 0.
- R9: `out_res` is 0 in every cycle in which `out_vld` is low.
- R10: Operations presented on consecutive cycles each produce their own correct result on consecutive cycles, with no stall and no lost operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operation present this cycle |
| in_op | input | 3 | Mode code (0..4 used, 5..7 give zero) |
| in_sgn_a | input | 1 | Operand A lanes are signed |
| in_sgn_b | input | 1 | Operand B lanes are signed |
| in_a | input | 32 | Packed operand A |
| in_b | input | 32 | Packed operand B |
| out_vld | output | 1 | Result present this cycle |
| out_res | output | 64 | Packed products or dot-product sum |

## Verification
Every fault in this block reaches the ports exactly two cycles after the operation that exposes it. Nothing is stored from one operation to the next, so a fault cannot stay hidden for long. A wrong lane extension or lane routing corrupts only one 16- or 32-bit field in the packed modes, but it corrupts the whole 32-bit sum in the dot modes. A faulty stage valid shows up as a missing or extra `out_vld` two cycles later, or as non-zero data while `out_vld` is low. The bench compares both output ports against a behavioural model on every cycle. It uses sign-boundary operands and all four signedness pairs so that extension errors become visible.

// File: rtl/pkd_mul_pkg.sv
// Shared mode codes and helpers for the packed multiply unit.
// Assumes a 3-bit mode field; codes above QDOT8 are reserved.
package pkd_mul_pkg;
    localparam logic [2:0] OP_MUL16  = 3'd0;
    localparam logic [2:0] OP_DMUL16 = 3'd1;
    localparam logic [2:0] OP_QMUL8  = 3'd2;
    localparam logic [2:0] OP_DDOT16 = 3'd3;
    localparam logic [2:0] OP_QDOT8  = 3'd4;

    // Number of lane multipliers; the quad byte modes fix it at four.
    localparam int LANES = 4;

    // True for modes that split operands into bytes.
    function automatic logic op_is_narrow(logic [2:0] op);
        return (op == OP_QMUL8) || (op == OP_QDOT8);
    endfunction

    // True for modes that split operands into 16-bit halves.
    function automatic logic op_is_wide(logic [2:0] op);
        return (op == OP_MUL16) || (op == OP_DMUL16) || (op == OP_DDOT16);
    endfunction
endpackage

// File: rtl/pkd_operand_split.sv
// Combinational operand router: feeds each lane multiplier a byte or a half
// of each operand, extended by one bit per the operand's signedness flag.
// Assumes LANES * NARROW_W is the operand width. Lanes a mode does not use
// get zero, so the downstream adder may sum all lanes blindly.
module pkd_operand_split
    import pkd_mul_pkg::*;
#(
    parameter int NARROW_W = 8,
    localparam int WIDE_W  = 2 * NARROW_W,
    localparam int OPER_W  = WIDE_W + 1,
    localparam int DATA_W  = LANES * NARROW_W
) (
    input  logic [2:0]                   op,
    input  logic                         sgn_a,
    input  logic                         sgn_b,
    input  logic [DATA_W-1:0]            a,
    input  logic [DATA_W-1:0]            b,
    output logic [LANES-1:0][OPER_W-1:0] lane_a,
    output logic [LANES-1:0][OPER_W-1:0] lane_b
);
    localparam int WIDE_LANES = DATA_W / WIDE_W;

    logic narrow_sel;
    logic wide_sel;

    assign narrow_sel = op_is_narrow(op);
    assign wide_sel   = op_is_wide(op);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OPER_W-1:0] nar_a, nar_b, wid_a, wid_b;

        // Byte slice of lane i, extended per operand flag.
        assign nar_a = {{(OPER_W-NARROW_W){sgn_a & a[i*NARROW_W+NARROW_W-1]}},
                        a[i*NARROW_W +: NARROW_W]};
        assign nar_b = {{(OPER_W-NARROW_W){sgn_b & b[i*NARROW_W+NARROW_W-1]}},
                        b[i*NARROW_W +: NARROW_W]};

        if (i < WIDE_LANES) begin : g_wide
            // Half slice of lane i, extended per operand flag.
            assign wid_a = {sgn_a & a[i*WIDE_W+WIDE_W-1], a[i*WIDE_W +: WIDE_W]};
            assign wid_b = {sgn_b & b[i*WIDE_W+WIDE_W-1], b[i*WIDE_W +: WIDE_W]};
        end else begin : g_idle
            // Upper lanes carry no half operand.
            assign wid_a = '0;
            assign wid_b = '0;
        end

        // Pick the slice the current mode needs; zero otherwise.
        assign lane_a[i] = narrow_sel ? nar_a : (wide_sel ? wid_a : '0);
        assign lane_b[i] = narrow_sel ? nar_b : (wide_sel ? wid_b : '0);
    end
endmodule

// File: rtl/pkd_lane_mul.sv
// One registered lane multiplier: signed OPER_W x OPER_W, product kept to
// PROD_W bits. Assumes the operands arrive already extended, so the kept
// bits are the exact two's-complement value of every legal lane product.
module pkd_lane_mul #(
    parameter int OPER_W = 17,
    parameter int PROD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPER_W-1:0] op_a,
    input  logic [OPER_W-1:0] op_b,
    output logic [PROD_W-1:0] prod
);
    logic signed [PROD_W-1:0] full;

    assign full = PROD_W'($signed(op_a)) * PROD_W'($signed(op_b));

    // Stage 1 register: capture the lane product every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prod <= '0;
        else        prod <= full;
    end
endmodule

// File: rtl/pkd_result_merge.sv
// Stage 2: packs lane products or sums them per mode, and registers the
// result with its valid flag. Assumes unused lanes hold zero products.
module pkd_result_merge
    import pkd_mul_pkg::*;
#(
    parameter int NARROW_W = 8,
    localparam int PROD_W  = 4 * NARROW_W,
    localparam int PACK_W  = 2 * NARROW_W,
    localparam int RES_W   = 2 * PROD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s1_vld,
    input  logic [2:0]                   s1_op,
    input  logic [LANES-1:0][PROD_W-1:0] prods,
    output logic                         out_vld,
    output logic [RES_W-1:0]             out_res
);
    logic [PROD_W-1:0] lane_sum;
    logic [RES_W-1:0]  byte_pack;
    logic [RES_W-1:0]  res_nxt;

    // Modulo-2^PROD_W sum of all lanes, shared by both dot modes.
    always_comb begin
        lane_sum = '0;
        for (int i = 0; i < LANES; i++) lane_sum = lane_sum + prods[i];
    end

    // Low PACK_W bits of each lane, packed lane 0 lowest.
    always_comb begin
        byte_pack = '0;
        for (int i = 0; i < LANES; i++) byte_pack[i*PACK_W +: PACK_W] = prods[i][PACK_W-1:0];
    end

    // Mode select; invalid or reserved gives zero.
    always_comb begin
        res_nxt = '0;
        if (s1_vld) begin
            case (s1_op)
                OP_MUL16:  res_nxt = {{PROD_W{1'b0}}, prods[0]};
                OP_DMUL16: res_nxt = {prods[1], prods[0]};
                OP_QMUL8:  res_nxt = byte_pack;
                OP_DDOT16: res_nxt = {{PROD_W{1'b0}}, lane_sum};
                OP_QDOT8:  res_nxt = {{PROD_W{1'b0}}, lane_sum};
                default:   res_nxt = '0;
            endcase
        end
    end

    // Stage 2 register: result and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_res <= '0;
        end else begin
            out_vld <= s1_vld;
            out_res <= res_nxt;
        end
    end

    // Output valid follows the stage-1 valid by one edge.
    assert_stage2_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(s1_vld)));

    // No data leaks while idle.
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_res == '0));

    // Reserved codes yield zero data.
    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && (s1_op > OP_QDOT8)) |=> (out_res == '0));

    // Single-result modes leave the upper word clear (R3, R6, R7).
    assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && (s1_op == OP_MUL16 || s1_op == OP_DDOT16 || s1_op == OP_QDOT8))
        |=> (out_res[RES_W-1:PROD_W] == '0));
endmodule

// File: rtl/pkd_mul_unit.sv
// Top of the packed SIMD multiply / dot-product unit. Two-stage pipeline:
// stage 1 holds lane products plus mode and valid, stage 2 packs or sums.
// Assumes NARROW_W-bit byte lanes; operands are 4 bytes, result 8 bytes.
module pkd_mul_unit
    import pkd_mul_pkg::*;
#(
    parameter int NARROW_W = 8,
    localparam int DATA_W  = LANES * NARROW_W,
    localparam int RES_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [2:0]        in_op,
    input  logic              in_sgn_a,
    input  logic              in_sgn_b,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_vld,
    output logic [RES_W-1:0]  out_res
);
    localparam int OPER_W = 2 * NARROW_W + 1;
    localparam int PROD_W = 4 * NARROW_W;

    logic [LANES-1:0][OPER_W-1:0] lane_a, lane_b;
    logic [LANES-1:0][PROD_W-1:0] prods;
    logic                         s1_vld;
    logic [2:0]                   s1_op;

    pkd_operand_split #(.NARROW_W(NARROW_W)) u_split (
        .op(in_op), .sgn_a(in_sgn_a), .sgn_b(in_sgn_b),
        .a(in_a), .b(in_b), .lane_a(lane_a), .lane_b(lane_b)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        pkd_lane_mul #(.OPER_W(OPER_W), .PROD_W(PROD_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .op_a(lane_a[i]), .op_b(lane_b[i]), .prod(prods[i])
        );
    end

    // Stage 1 control: carry valid and mode beside the lane products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_op  <= '0;
        end else begin
            s1_vld <= in_vld;
            s1_op  <= in_op;
        end
    end

    pkd_result_merge #(.NARROW_W(NARROW_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .s1_vld(s1_vld), .s1_op(s1_op),
        .prods(prods), .out_vld(out_vld), .out_res(out_res)
    );

    // Stage-1 valid tracks the input valid one edge later.
    assert_stage1_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (s1_vld == $past(in_vld)));

    // Back-to-back accepts both emerge: a valid two edges back gives a valid now.
    assert_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(in_vld, 2)) |-> out_vld);
endmodule

// File: tb/pkd_mul_unit_tb.sv
// Bench: behavioural model with a two-deep expectation pipe, compared on
// every falling edge; inputs driven on falling edges.
module pkd_mul_unit_tb;
    typedef struct packed {
        logic        rst;
        logic        vld;
        logic [2:0]  op;
        logic [63:0] res;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_sgn_a = 1'b0;
    logic        in_sgn_b = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_vld;
    logic [63:0] out_res;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    exp_t d1 = '{rst: 1'b1, vld: 1'b0, op: 3'd0, res: 64'd0};
    exp_t d2 = '{rst: 1'b1, vld: 1'b0, op: 3'd0, res: 64'd0};

    always #2.5 clk = ~clk;

    pkd_mul_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_sgn_a(in_sgn_a), .in_sgn_b(in_sgn_b), .in_a(in_a), .in_b(in_b),
        .out_vld(out_vld), .out_res(out_res)
    );

    function automatic longint xval(logic [15:0] v, int w, logic s);
        if (w == 8) return s ? longint'($signed(v[7:0])) : longint'(v[7:0]);
        return s ? longint'($signed(v)) : longint'(v);
    endfunction

    function automatic logic [63:0] model(logic [2:0] op, logic sa, logic sb,
                                          logic [31:0] a, logic [31:0] b);
        logic [63:0] r = '0;
        longint      sum = 0;
        longint      p;
        case (op)
            3'd0: begin
                p = xval(a[15:0], 16, sa) * xval(b[15:0], 16, sb);
                r[31:0] = 32'(p);
            end
            3'd1: begin
                for (int k = 0; k < 2; k++) begin
                    p = xval(a[16*k +: 16], 16, sa) * xval(b[16*k +: 16], 16, sb);
                    r[32*k +: 32] = 32'(p);
                end
            end
            3'd2: begin
                for (int k = 0; k < 4; k++) begin
                    p = xval({8'd0, a[8*k +: 8]}, 8, sa) * xval({8'd0, b[8*k +: 8]}, 8, sb);
                    r[16*k +: 16] = 16'(p);
                end
            end
            3'd3: begin
                for (int k = 0; k < 2; k++)
                    sum += xval(a[16*k +: 16], 16, sa) * xval(b[16*k +: 16], 16, sb);
                r[31:0] = 32'(sum);
            end
            3'd4: begin
                for (int k = 0; k < 4; k++)
                    sum += xval({8'd0, a[8*k +: 8]}, 8, sa) * xval({8'd0, b[8*k +: 8]}, 8, sb);
                r[31:0] = 32'(sum);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag(exp_t e);
        if (e.rst) return "R1";
        if (!e.vld) return "R9";
        case (e.op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // One cycle: check the entry from two cycles back, then drive new input.
    task automatic step(logic r, logic v, logic [2:0] op, logic sa, logic sb,
                        logic [31:0] a, logic [31:0] b);
        exp_t e;
        @(negedge clk);
        checks++;
        if (out_vld !== d2.vld || out_res !== d2.res) begin
            errors++;
            $display("FAIL %s (latency R2) got vld=%b res=%h expected vld=%b res=%h",
                     tag(d2), out_vld, out_res, d2.vld, d2.res);
        end
        d2 = d1;
        e.rst = !r;
        e.vld = r & v;
        e.op  = op;
        e.res = (r & v) ? model(op, sa, sb, a, b) : 64'd0;
        d1 = e;
        rst_n = r; in_vld = v; in_op = op;
        in_sgn_a = sa; in_sgn_b = sb; in_a = a; in_b = b;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: an overrun counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired got cycle=%0d expected below 150000", cyc);
            summary();
        end
    end

    initial begin
        // R1: valid inputs during reset must not reach the outputs.
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 3'd1, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h7FFF_8000);
        // R3: every signedness pair at the 16-bit extremes.
        for (int s = 0; s < 4; s++) step(1'b1, 1'b1, 3'd0, s[1], s[0], 32'h1234_FFFF, 32'h5678_FFFF);
        step(1'b1, 1'b1, 3'd0, 1'b1, 1'b1, 32'h0000_8000, 32'h0000_8000);
        step(1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 32'h0000_8000, 32'h0000_FFFF);
        // R4: halves independent, mixed signs.
        step(1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 32'h8000_0003, 32'hFFFF_7FFF);
        step(1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h8000_0001);
        // R5: byte lanes at sign boundaries.
        for (int s = 0; s < 4; s++) step(1'b1, 1'b1, 3'd2, s[1], s[0], 32'h80FF_7F01, 32'h80FF_FF80);
        // R6: wrap of the dual sum, signed and unsigned.
        step(1'b1, 1'b1, 3'd3, 1'b1, 1'b1, 32'h8000_8000, 32'h8000_8000);
        step(1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b1, 1'b1, 3'd3, 1'b1, 1'b0, 32'h8000_0001, 32'hFFFF_0002);
        // R7: quad sum with negative and large lanes.
        for (int s = 0; s < 4; s++) step(1'b1, 1'b1, 3'd4, s[1], s[0], 32'h8080_8080, 32'hFF80_FF80);
        // R8: reserved codes give zero.
        for (int k = 5; k < 8; k++) step(1'b1, 1'b1, 3'(k), 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R9: idle cycles with busy data on the inputs.
        step(1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D);
        // R10: back-to-back stream cycling through every mode.
        for (int i = 0; i < 64; i++)
            step(1'b1, 1'b1, 3'(i % 8), i[0], i[1], $urandom, $urandom);
        // Random mix with gaps.
        for (int i = 0; i < 3000; i++)
            step(1'b1, ($urandom % 4) != 0, 3'($urandom % 8), 1'($urandom), 1'($urandom),
                 $urandom, $urandom);
        // Drain the pipe.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 32'd0, 32'd0);
        done = 1'b1;
        summary();
    end
endmodule